// File: doc/BRIEF.md
# Condition Flag Update Unit

This unit owns the 32-bit current status word of a processor core. Once per operation it takes the finished result of the datapath together with the adder's carry, borrow and signed-overflow outputs, the shifter's carry-out and an operation class. From these it decides whether the four condition flags (negative, zero, carry, overflow) change, and to what. The carry rule depends on the class. After an addition the carry is the adder's carry-out. After a subtraction the carry is the inverse of the borrow. A logical operation that used the shifter takes the shifter's last bit out. A plain logical operation keeps the old carry.

A set-flags operation aimed at the program counter does not compute flags at all. It restores the whole status word from the saved status value presented at its input. An explicit status write loads the word directly. A separate sticky input sets the saturation flag, and only a write or a restore can clear it again. Unimplemented bits always read as zero.

Top module: `cond_flag_unit`

## Requirements
- R1: After reset the status word is 0x000000D3: mode field [4:0] = 5'b10011, both interrupt masks (bits 7 and 6) set, state bit 5 clear, and all flags clear.
- R2: On a flag update the negative flag (bit 31) takes the most significant bit of `result`, and the zero flag (bit 30) is 1 exactly when `result` is all zeros.
- R3: On a flag update the carry flag (bit 29) takes `add_carry` for class add (`op_class` = 0) and the inverse of `sub_borrow` for class subtract (`op_class` = 1).
- R4: On a flag update the carry flag takes `shift_carry` for class shift-logical (`op_class` = 2) and keeps its value for class logical (`op_class` = 3). Class none (`op_class` = 4, and the unused codes 5 to 7) leaves all four flags unchanged.
- R5: On a flag update the overflow flag (bit 28) takes `arith_ovf` for the add and subtract classes and keeps its value for every other class.
- R6: A flag update happens only when `upd_valid` is 1, and then either because `is_compare` is 1 or because `set_flags` is 1 and `dest_is_pc` is 0. With `upd_valid` at 0 the operation inputs have no effect.
- R7: When `upd_valid`, `set_flags` and `dest_is_pc` are 1 and `is_compare` is 0, the status word is loaded from `saved_word`, and no flags are computed.
- R8: Bits 26 down to 8 of the status word always read as zero. The bits written by a restore or an explicit write are masked with 0xF80000FF.
- R9: `sat_set` sets the saturation flag (bit 27) on the next edge. The flag then stays set until an explicit write or a restore loads a value with bit 27 clear.
- R10: `wr_en` loads the masked `wr_word` and takes precedence over a restore or a flag update in the same cycle. A `sat_set` in that same cycle still leaves bit 27 set.
- R11: Bits 7 down to 0 change only through reset, a restore or an explicit write.
- R12: Every change appears on `status_word` one clock edge after the cycle in which the inputs are presented. Reset is applied asynchronously and released through a two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | An operation completes this cycle |
| op_class | input | 3 | 0 add, 1 subtract, 2 shift-logical, 3 logical, 4 none |
| is_compare | input | 1 | Operation is a compare type (always updates flags) |
| set_flags | input | 1 | Set-flags qualifier present |
| dest_is_pc | input | 1 | Destination register is the program counter |
| result | input | DATA_W | Operation result |
| add_carry | input | 1 | Adder carry-out |
| sub_borrow | input | 1 | Subtractor borrow-out |
| shift_carry | input | 1 | Last bit shifted out by the shifter |
| arith_ovf | input | 1 | Adder signed overflow |
| sat_set | input | 1 | Sticky set of the saturation flag |
| wr_en | input | 1 | Explicit status write strobe |
| wr_word | input | 32 | Explicit status write value |
| saved_word | input | 32 | Saved status value used by a restore |
| status_word | output | 32 | Current status word |

## Verification
The bench builds the unit with `DATA_W` = 8. At that width every result value, including zero, both sign values and every non-zero value in between, can be swept under every class and every combination of the four carry and overflow inputs. A second sweep runs all sixteen combinations of the valid, compare, set-flags and program-counter-destination controls. It confirms which of those combinations update the flags, which restore the word and which do nothing. Directed sequences then cover the saturation flag's persistence, the precedence of a write over an update, and the masking of all-ones values written into the word.

// File: rtl/cfu_pkg.sv
package cfu_pkg;

  localparam int STAT_W = 32;

  typedef enum logic [2:0] {
    OPC_ADD   = 3'd0,
    OPC_SUB   = 3'd1,
    OPC_SHLOG = 3'd2,
    OPC_LOG   = 3'd3,
    OPC_NONE  = 3'd4
  } opc_e;

  localparam int BIT_N = 31;
  localparam int BIT_Z = 30;
  localparam int BIT_C = 29;
  localparam int BIT_V = 28;
  localparam int BIT_Q = 27;

  localparam logic [STAT_W-1:0] IMPL_MASK  = 32'hF800_00FF;
  localparam logic [STAT_W-1:0] RESET_WORD = 32'h0000_00D3;

  typedef struct packed {
    logic n;
    logic z;
    logic c;
    logic v;
  } nzcv_t;

endpackage

// File: rtl/cfu_rst_sync.sv
module cfu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_ni,
  output logic rst_no
);

  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_no = sync_q[STAGES-1];

endmodule

// File: rtl/cfu_flag_calc.sv
module cfu_flag_calc
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [2:0]        opc,
  input  logic [DATA_W-1:0] result,
  input  logic              add_carry,
  input  logic              sub_borrow,
  input  logic              shift_carry,
  input  logic              arith_ovf,
  input  nzcv_t             cur_flags,
  output nzcv_t             new_flags
);

  localparam int MSB = DATA_W - 1;

  logic res_neg;
  logic res_zero;

  always_comb begin
    res_neg  = result[MSB];
    res_zero = (result == '0);
  end

  always_comb begin
    new_flags = cur_flags;
    case (opc)
      OPC_ADD: begin
        new_flags.n = res_neg;
        new_flags.z = res_zero;
        new_flags.c = add_carry;
        new_flags.v = arith_ovf;
      end
      OPC_SUB: begin
        new_flags.n = res_neg;
        new_flags.z = res_zero;
        new_flags.c = ~sub_borrow;
        new_flags.v = arith_ovf;
      end
      OPC_SHLOG: begin
        new_flags.n = res_neg;
        new_flags.z = res_zero;
        new_flags.c = shift_carry;
      end
      OPC_LOG: begin
        new_flags.n = res_neg;
        new_flags.z = res_zero;
      end
      default: begin
        new_flags = cur_flags;
      end
    endcase
  end

endmodule

// File: rtl/cfu_next_word.sv
module cfu_next_word
  import cfu_pkg::*;
(
  input  logic [STAT_W-1:0] cur_word,
  input  nzcv_t             new_flags,
  input  logic              flag_upd,
  input  logic              restore,
  input  logic              wr_en,
  input  logic [STAT_W-1:0] wr_word,
  input  logic [STAT_W-1:0] saved_word,
  input  logic              sat_set,
  output logic [STAT_W-1:0] nxt_word,
  output logic              load_en
);

  logic [STAT_W-1:0] base_word;

  always_comb begin
    base_word = cur_word;
    if (wr_en) begin
      base_word = wr_word & IMPL_MASK;
    end else if (restore) begin
      base_word = saved_word & IMPL_MASK;
    end else if (flag_upd) begin
      base_word[BIT_N] = new_flags.n;
      base_word[BIT_Z] = new_flags.z;
      base_word[BIT_C] = new_flags.c;
      base_word[BIT_V] = new_flags.v;
    end
  end

  always_comb begin
    nxt_word = base_word;
    if (sat_set) begin
      nxt_word[BIT_Q] = 1'b1;
    end
  end

  assign load_en = wr_en | restore | flag_upd | sat_set;

endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import cfu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  logic [2:0]        op_class,
  input  logic              is_compare,
  input  logic              set_flags,
  input  logic              dest_is_pc,
  input  logic [DATA_W-1:0] result,
  input  logic              add_carry,
  input  logic              sub_borrow,
  input  logic              shift_carry,
  input  logic              arith_ovf,
  input  logic              sat_set,
  input  logic              wr_en,
  input  logic [31:0]       wr_word,
  input  logic [31:0]       saved_word,
  output logic [31:0]       status_word
);

  logic              rst_sync_n;
  logic              flag_upd;
  logic              restore;
  logic              load_en;
  nzcv_t             cur_flags;
  nzcv_t             new_flags;
  logic [STAT_W-1:0] stat_q;
  logic [STAT_W-1:0] stat_d;

  cfu_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk    (clk),
    .rst_ni (rst_n),
    .rst_no (rst_sync_n)
  );

  always_comb begin
    flag_upd = upd_valid & (is_compare | (set_flags & ~dest_is_pc));
    restore  = upd_valid & ~is_compare & set_flags & dest_is_pc;
    cur_flags = '{n: stat_q[BIT_N], z: stat_q[BIT_Z],
                  c: stat_q[BIT_C], v: stat_q[BIT_V]};
  end

  cfu_flag_calc #(.DATA_W(DATA_W)) u_flag_calc (
    .opc         (op_class),
    .result      (result),
    .add_carry   (add_carry),
    .sub_borrow  (sub_borrow),
    .shift_carry (shift_carry),
    .arith_ovf   (arith_ovf),
    .cur_flags   (cur_flags),
    .new_flags   (new_flags)
  );

  cfu_next_word u_next_word (
    .cur_word   (stat_q),
    .new_flags  (new_flags),
    .flag_upd   (flag_upd),
    .restore    (restore),
    .wr_en      (wr_en),
    .wr_word    (wr_word),
    .saved_word (saved_word),
    .sat_set    (sat_set),
    .nxt_word   (stat_d),
    .load_en    (load_en)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      stat_q <= RESET_WORD;
    end else if (load_en) begin
      stat_q <= stat_d;
    end
  end

  assign status_word = stat_q;

  // R8
  rsv_zero_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    stat_q[26:8] == '0);

  // R9
  q_set_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    sat_set |=> stat_q[BIT_Q]);

  // R9
  q_sticky_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (stat_q[BIT_Q] && !wr_en && !restore) |=> stat_q[BIT_Q]);

  // R11
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!wr_en && !restore) |=> $stable(stat_q[7:0]));

  // R5
  v_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (flag_upd && !wr_en && op_class != OPC_ADD && op_class != OPC_SUB)
      |=> $stable(stat_q[BIT_V]));

  // R6
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!upd_valid && !wr_en && !sat_set) |=> $stable(stat_q));

endmodule

// File: tb/cond_flag_unit_tb_top.sv
`timescale 1ns/1ps
module cond_flag_unit_tb_top;

  localparam int DW = 8;
  localparam logic [31:0] MASK = 32'hF800_00FF;

  logic          clk;
  logic          rst_n;
  logic          upd_valid;
  logic [2:0]    op_class;
  logic          is_compare;
  logic          set_flags;
  logic          dest_is_pc;
  logic [DW-1:0] result;
  logic          add_carry;
  logic          sub_borrow;
  logic          shift_carry;
  logic          arith_ovf;
  logic          sat_set;
  logic          wr_en;
  logic [31:0]   wr_word;
  logic [31:0]   saved_word;
  logic [31:0]   status_word;

  int          n_chk;
  int          n_bad;
  logic [31:0] exp_word;
  bit          done;

  cond_flag_unit #(.DATA_W(DW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .upd_valid   (upd_valid),
    .op_class    (op_class),
    .is_compare  (is_compare),
    .set_flags   (set_flags),
    .dest_is_pc  (dest_is_pc),
    .result      (result),
    .add_carry   (add_carry),
    .sub_borrow  (sub_borrow),
    .shift_carry (shift_carry),
    .arith_ovf   (arith_ovf),
    .sat_set     (sat_set),
    .wr_en       (wr_en),
    .wr_word     (wr_word),
    .saved_word  (saved_word),
    .status_word (status_word)
  );

  initial begin
    clk = 1'b0;
    forever #2 clk = ~clk;
  end

  function automatic logic [31:0] model(input logic [31:0] cur);
    logic [31:0] w;
    logic fu;
    logic rs;
    w  = cur;
    fu = upd_valid & (is_compare | (set_flags & ~dest_is_pc));
    rs = upd_valid & ~is_compare & set_flags & dest_is_pc;
    if (wr_en) begin
      w = wr_word & MASK;
    end else if (rs) begin
      w = saved_word & MASK;
    end else if (fu && op_class <= 3'd3) begin
      w[31] = result[DW-1];
      w[30] = (result == 0);
      if (op_class == 3'd0) begin w[29] = add_carry;   w[28] = arith_ovf; end
      if (op_class == 3'd1) begin w[29] = !sub_borrow; w[28] = arith_ovf; end
      if (op_class == 3'd2) begin w[29] = shift_carry; end
    end
    if (sat_set) w[27] = 1'b1;
    return w;
  endfunction

  task automatic compare(input string tag, input logic [31:0] exp);
    n_chk++;
    if (status_word !== exp) begin
      n_bad++;
      $display("FAIL %s: status_word actual=%08h expected=%08h", tag, status_word, exp);
    end
  endtask

  task automatic set_idle();
    upd_valid = 0; op_class = 3'd4; is_compare = 0; set_flags = 0; dest_is_pc = 0;
    result = '0; add_carry = 0; sub_borrow = 0; shift_carry = 0; arith_ovf = 0;
    sat_set = 0; wr_en = 0; wr_word = '0; saved_word = '0;
  endtask

  // Inputs are set before the call (after a negedge); the register loads at the
  // next posedge and the output is sampled 1 ns later.
  task automatic cycle(input string tag);
    logic [31:0] nxt;
    nxt = model(exp_word);
    @(posedge clk);
    #1;
    compare(tag, nxt);
    exp_word = status_word;
    @(negedge clk);
    set_idle();
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 0;
    set_idle();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state, R12 synchronous release
    exp_word = 32'h0000_00D3;
    compare("R1 R12", exp_word);

    // R2 R3 R4 R5 R11: exhaustive class x result x carry/overflow sweep
    for (int oc = 0; oc < 8; oc++) begin
      for (int rv = 0; rv < 256; rv++) begin
        for (int cv = 0; cv < 16; cv++) begin
          upd_valid = 1; set_flags = 1; op_class = oc[2:0];
          result = rv[DW-1:0];
          add_carry = cv[0]; sub_borrow = cv[1]; shift_carry = cv[2]; arith_ovf = cv[3];
          if (oc < 2)       cycle("R2 R3 R5 R11");
          else if (oc < 4)  cycle("R2 R4 R5 R11");
          else              cycle("R4 R11");
        end
      end
    end

    // R6 R7: control combinations, restore mask R8
    for (int k = 0; k < 16; k++) begin
      for (int rv = 0; rv < 4; rv++) begin
        upd_valid = k[0]; is_compare = k[1]; set_flags = k[2]; dest_is_pc = k[3];
        op_class = rv[0] ? 3'd1 : 3'd0;
        result = (rv == 0) ? 8'h00 : (rv == 1 ? 8'h80 : 8'h5A);
        add_carry = rv[1]; sub_borrow = ~rv[0]; arith_ovf = rv[0];
        saved_word = (rv == 2) ? 32'hFFFF_FFFF : 32'h5A5A_A5C4 ^ {28'd0, rv[3:0]};
        cycle("R6 R7 R8");
      end
    end

    // R9: sticky saturation flag survives updates, cleared by restore
    sat_set = 1; cycle("R9");
    compare("R9", exp_word | 32'h0800_0000);
    upd_valid = 1; set_flags = 1; op_class = 3'd0; result = 8'h00; cycle("R9");
    upd_valid = 1; is_compare = 1; op_class = 3'd1; result = 8'hFF; sub_borrow = 1; cycle("R9");
    upd_valid = 1; set_flags = 1; dest_is_pc = 1; saved_word = 32'h6000_0010; cycle("R7 R9");
    compare("R7 R9", 32'h6000_0010);
    sat_set = 1; cycle("R9");

    // R10: write beats update and restore; sat_set still sets Q
    wr_en = 1; wr_word = 32'hFFFF_FFFF; upd_valid = 1; set_flags = 1; op_class = 3'd0;
    result = 8'h00; cycle("R10 R8");
    compare("R10 R8", 32'hF800_00FF);
    wr_en = 1; wr_word = 32'h0000_0011; upd_valid = 1; set_flags = 1; dest_is_pc = 1;
    saved_word = 32'hF000_001F; cycle("R10");
    compare("R10", 32'h0000_0011);
    wr_en = 1; wr_word = 32'h2000_0017; sat_set = 1; cycle("R10 R9");
    compare("R10 R9", 32'h2800_0017);

    // R6: operation inputs ignored without upd_valid
    op_class = 3'd0; set_flags = 1; is_compare = 1; result = 8'hFF; add_carry = 1;
    arith_ovf = 1; cycle("R6");
    compare("R6", 32'h2800_0017);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule